// File: doc/BRIEF.md
# Cable Driver Control and Fault Logic

This block holds the digital control for a cable driver with two (parameterizable) serial video outputs. It takes an edge-rate pin, a power enable pin, a "signal present" flag from the input detector and one termination-fault flag per output. All of these are asynchronous, and each passes through a synchronizer. From them, and from a few configuration bits held elsewhere in a register bank, the block sets the edge-rate select, the enable of each output driver, and the action taken on loss of signal: add an input offset, or mute the outputs. It also drives the open-drain FAULT pull-down request.

A three-state machine tracks the operating mode. ST_OFF is the power-save state, entered whenever the synchronized enable is low; it is also the reset state. ST_RUN means enabled with a signal present. ST_LOST means enabled with the signal missing. The transitions are named as follows. OFF_TO_RUN happens when enable is high and the signal is present. OFF_TO_LOST happens when enable is high and the signal is absent. RUN_TO_LOST and LOST_TO_RUN follow the signal flag. RUN_TO_OFF and LOST_TO_OFF happen when enable falls. A status vector reports the cause of a fault: bit 0 is loss of signal, and bit k+1 is a termination fault on output k. The status comes in two forms. The live form follows the inputs. The sticky form holds each bit until software clears it by writing 1 to that bit.

Top module: `drvctl_top`

## Requirements
- R1: `slew_slow` is the OR of the synchronized edge-rate pin and `cfg_sd_slow`. The register bit only matters while the pin is low.
- R2: Every pin and detector flag passes through `SYNC_STAGES` flip-flops. All outputs settle no later than `SYNC_STAGES+2` clock edges after an input change.
- R3: While the enable pin is low (ST_OFF), every bit of `drv_en` is 0, `power_save` is 1, and `los_offset` and `los_mute` are both 0.
- R4: With enable high and the signal present (ST_RUN), every bit of `drv_en` is 1 and both loss actions are 0.
- R5: With enable high and the signal absent (ST_LOST), `los_offset` equals NOT `cfg_los_mute` and `los_mute` equals `cfg_los_mute`. The two are never high together.
- R6: In ST_LOST with `cfg_los_mute`=1, every bit of `drv_en` is 0.
- R7: In ST_LOST with `cfg_los_link`=1, every bit of `drv_en` is 0. With both `cfg_los_link`=0 and `cfg_los_mute`=0, the drivers stay on.
- R8: `stat_live` bit 0 equals NOT the synchronized signal-present flag. Bit k+1 equals the synchronized termination fault of output k ANDed with `drv_en[k]`, so the bit is forced to 0 while that driver is off.
- R9: `stat_sticky` sets one cycle after the matching live bit is 1. A bit clears on a `clr_wr` cycle whose `clr_data` bit is 1, and a set in the same cycle wins over the clear. A clear of one bit leaves the other bits unchanged.
- R10: `fault_pull` is 1 (pull FAULT low) when any live bit whose `cfg_mask` bit is 0 is set. `cfg_mask` uses the same bit layout as the status.
- R11: After reset, the block is in ST_OFF, and `stat_sticky`, `fault_pull` and `slew_slow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_sd_a | input | 1 | Edge-rate pin, high = slow edges |
| pin_en_a | input | 1 | Driver enable pin, low = power save |
| sig_ok_a | input | 1 | Input detector: 1 = video-like signal present |
| term_flt_a | input | NOUT | Per-output termination fault flags |
| cfg_sd_slow | input | 1 | Register copy of the slow-edge select |
| cfg_los_mute | input | 1 | Loss action: 0 = add offset, 1 = mute |
| cfg_los_link | input | 1 | Loss of signal also drops the driver enables |
| cfg_mask | input | NOUT+1 | Fault masks, same layout as status |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | NOUT+1 | Write-1-to-clear bits for sticky status |
| slew_slow | output | 1 | Effective edge-rate select |
| drv_en | output | NOUT | Per-output driver enable |
| los_offset | output | 1 | Add input offset |
| los_mute | output | 1 | Mute outputs |
| power_save | output | 1 | Deep power-save indication |
| fault_pull | output | 1 | Drive the open-drain FAULT line low |
| stat_live | output | NOUT+1 | Live fault causes |
| stat_sticky | output | NOUT+1 | Sticky fault causes |

## Verification
The bench builds the block with NOUT=2 and SYNC_STAGES=2, so the status and mask vectors are three bits wide. This size keeps every combination of enable, signal, per-output fault and mask within reach of a few dozen random draws. The two-stage synchronizer sets a fixed settle window of four edges, and the bench waits past that window before each comparison. Directed cases cover a sticky bit surviving after its live source clears, a clear aimed at a different bit, and termination faults raised while the drivers are off.

// File: rtl/drvctl_pkg.sv
package drvctl_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOST = 2'd2
    } drv_state_t;
endpackage

// File: rtl/drvctl_sync.sv
module drvctl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q_s
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= '0;
                end else if (g == 0) begin
                    chain[g] <= d_a;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_s = chain[STAGES-1];
endmodule

// File: rtl/drvctl_mode_fsm.sv
module drvctl_mode_fsm
    import drvctl_pkg::*;
#(
    parameter int NOUT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_s,
    input  logic            sig_ok_s,
    input  logic            cfg_los_mute,
    input  logic            cfg_los_link,
    output logic [NOUT-1:0] drv_en,
    output logic            los_offset,
    output logic            los_mute,
    output logic            power_save
);
    drv_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_s && sig_ok_s)       state_d = ST_RUN;   // OFF_TO_RUN
                else if (en_s)              state_d = ST_LOST;  // OFF_TO_LOST
            end
            ST_RUN: begin
                if (!en_s)                  state_d = ST_OFF;   // RUN_TO_OFF
                else if (!sig_ok_s)         state_d = ST_LOST;  // RUN_TO_LOST
            end
            ST_LOST: begin
                if (!en_s)                  state_d = ST_OFF;   // LOST_TO_OFF
                else if (sig_ok_s)          state_d = ST_RUN;   // LOST_TO_RUN
            end
            default:                        state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        drv_en     = '0;
        los_offset = 1'b0;
        los_mute   = 1'b0;
        power_save = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                power_save = 1'b1;
            end
            ST_RUN: begin
                drv_en = '1;
            end
            ST_LOST: begin
                los_offset = !cfg_los_mute;
                los_mute   = cfg_los_mute;
                drv_en     = (cfg_los_mute || cfg_los_link) ? '0 : '1;
            end
            default: begin
                power_save = 1'b1;
            end
        endcase
    end

    assert_off_drivers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (drv_en == '0 && power_save));

    assert_one_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({los_offset, los_mute}));

    assert_run_drivers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && sig_ok_s) |=> (drv_en == '1 && !los_offset && !los_mute));
endmodule

// File: rtl/drvctl_fault_agg.sv
module drvctl_fault_agg #(
    parameter int NOUT = 2,
    localparam int SW  = NOUT + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sig_ok_s,
    input  logic [NOUT-1:0] term_s,
    input  logic [NOUT-1:0] drv_en,
    input  logic [SW-1:0]   cfg_mask,
    input  logic            clr_wr,
    input  logic [SW-1:0]   clr_data,
    output logic [SW-1:0]   stat_live,
    output logic [SW-1:0]   stat_sticky,
    output logic            fault_pull
);
    logic [SW-1:0] clr_vec;

    assign stat_live = {term_s & drv_en, !sig_ok_s};
    assign clr_vec   = clr_wr ? clr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_sticky <= '0;
            fault_pull  <= 1'b0;
        end else begin
            stat_sticky <= (stat_sticky & ~clr_vec) | stat_live;
            fault_pull  <= |(stat_live & ~cfg_mask);
        end
    end

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((stat_sticky & $past(stat_sticky)) == $past(stat_sticky)));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&cfg_mask) |=> !fault_pull);

    assert_term_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_live[SW-1:1] & ~drv_en) == '0));
endmodule

// File: rtl/drvctl_top.sv
module drvctl_top #(
    parameter int NOUT        = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SW         = NOUT + 1,
    localparam int IW         = NOUT + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_sd_a,
    input  logic            pin_en_a,
    input  logic            sig_ok_a,
    input  logic [NOUT-1:0] term_flt_a,
    input  logic            cfg_sd_slow,
    input  logic            cfg_los_mute,
    input  logic            cfg_los_link,
    input  logic [SW-1:0]   cfg_mask,
    input  logic            clr_wr,
    input  logic [SW-1:0]   clr_data,
    output logic            slew_slow,
    output logic [NOUT-1:0] drv_en,
    output logic            los_offset,
    output logic            los_mute,
    output logic            power_save,
    output logic            fault_pull,
    output logic [SW-1:0]   stat_live,
    output logic [SW-1:0]   stat_sticky
);
    logic [IW-1:0]   raw_a, raw_s;
    logic            sd_s, en_s, sig_ok_s;
    logic [NOUT-1:0] term_s;

    assign raw_a = {term_flt_a, sig_ok_a, pin_en_a, pin_sd_a};
    assign {term_s, sig_ok_s, en_s, sd_s} = raw_s;

    drvctl_sync #(.W(IW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   (raw_a),
        .q_s   (raw_s)
    );

    assign slew_slow = sd_s | cfg_sd_slow;

    drvctl_mode_fsm #(.NOUT(NOUT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_s         (en_s),
        .sig_ok_s     (sig_ok_s),
        .cfg_los_mute (cfg_los_mute),
        .cfg_los_link (cfg_los_link),
        .drv_en       (drv_en),
        .los_offset   (los_offset),
        .los_mute     (los_mute),
        .power_save   (power_save)
    );

    drvctl_fault_agg #(.NOUT(NOUT)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_ok_s    (sig_ok_s),
        .term_s      (term_s),
        .drv_en      (drv_en),
        .cfg_mask    (cfg_mask),
        .clr_wr      (clr_wr),
        .clr_data    (clr_data),
        .stat_live   (stat_live),
        .stat_sticky (stat_sticky),
        .fault_pull  (fault_pull)
    );

    assert_pin_slow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sd_s |-> slew_slow);
endmodule

// File: tb/drvctl_top_tb.sv
module drvctl_top_tb;
    localparam int NOUT = 2;
    localparam int SW   = NOUT + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pin_sd_a = 1'b0, pin_en_a = 1'b0, sig_ok_a = 1'b0;
    logic [NOUT-1:0] term_flt_a = '0;
    logic            cfg_sd_slow = 1'b0, cfg_los_mute = 1'b0, cfg_los_link = 1'b0;
    logic [SW-1:0]   cfg_mask = '0;
    logic            clr_wr = 1'b0;
    logic [SW-1:0]   clr_data = '0;
    logic            slew_slow, los_offset, los_mute, power_save, fault_pull;
    logic [NOUT-1:0] drv_en;
    logic [SW-1:0]   stat_live, stat_sticky;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    drvctl_top #(.NOUT(NOUT), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_sd_a(pin_sd_a), .pin_en_a(pin_en_a),
        .sig_ok_a(sig_ok_a), .term_flt_a(term_flt_a), .cfg_sd_slow(cfg_sd_slow),
        .cfg_los_mute(cfg_los_mute), .cfg_los_link(cfg_los_link), .cfg_mask(cfg_mask),
        .clr_wr(clr_wr), .clr_data(clr_data), .slew_slow(slew_slow), .drv_en(drv_en),
        .los_offset(los_offset), .los_mute(los_mute), .power_save(power_save),
        .fault_pull(fault_pull), .stat_live(stat_live), .stat_sticky(stat_sticky)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [NOUT-1:0] exp_drv(input logic en, input logic ok,
                                                input logic mute, input logic link);
        if (!en)               return '0;
        if (ok)                return '1;
        if (mute || link)      return '0;
        return '1;
    endfunction

    function automatic logic [SW-1:0] exp_live(input logic ok, input logic [NOUT-1:0] t,
                                               input logic [NOUT-1:0] de);
        return {t & de, !ok};
    endfunction

    task automatic clear_bits(input logic [SW-1:0] bits);
        clr_data = bits;
        clr_wr   = 1'b1;
        @(negedge clk);
        clr_wr   = 1'b0;
        clr_data = '0;
    endtask

    task automatic check_all();
        logic [NOUT-1:0] de;
        logic [SW-1:0]   lv;
        de = exp_drv(pin_en_a, sig_ok_a, cfg_los_mute, cfg_los_link);
        lv = exp_live(sig_ok_a, term_flt_a, de);
        check("R1 slew", 32'(slew_slow), 32'(pin_sd_a | cfg_sd_slow));
        check("R3/R4/R6/R7 drv_en", 32'(drv_en), 32'(de));
        check("R3 power_save", 32'(power_save), 32'(!pin_en_a));
        check("R5 los_offset", 32'(los_offset), 32'(pin_en_a && !sig_ok_a && !cfg_los_mute));
        check("R5 los_mute", 32'(los_mute), 32'(pin_en_a && !sig_ok_a && cfg_los_mute));
        check("R8 stat_live", 32'(stat_live), 32'(lv));
        check("R10 fault_pull", 32'(fault_pull), 32'(|(lv & ~cfg_mask)));
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1307));
        settle(3);
        check("R11 reset power_save", 32'(power_save), 32'd1);
        check("R11 reset sticky", 32'(stat_sticky), 32'd0);
        check("R11 reset fault", 32'(fault_pull), 32'd0);
        check("R11 reset slew", 32'(slew_slow), 32'd0);
        rst_n = 1'b1;
        settle(6);
        check_all();

        // R1 directed: pin high overrides register low; register acts with pin low
        pin_sd_a = 1'b1; cfg_sd_slow = 1'b0; settle(6);
        check("R1 pin high", 32'(slew_slow), 32'd1);
        pin_sd_a = 1'b0; cfg_sd_slow = 1'b1; settle(6);
        check("R1 register with pin low", 32'(slew_slow), 32'd1);
        cfg_sd_slow = 1'b0; settle(1);
        check("R1 both low", 32'(slew_slow), 32'd0);

        // R2 latency: enable rises; drivers must follow within 4 edges, not 1
        sig_ok_a = 1'b1; settle(6);
        pin_en_a = 1'b1; settle(1);
        check("R2 not before sync", 32'(drv_en), 32'd0);
        settle(3);
        check("R2 settled in window", 32'(drv_en), 32'(3));

        // R9: loss pulse leaves sticky bit 0 while live clears
        clear_bits('1); settle(2);
        sig_ok_a = 1'b0; settle(6);
        sig_ok_a = 1'b1; settle(6);
        check("R9 sticky kept", 32'(stat_sticky[0]), 32'd1);
        check("R9 live clear", 32'(stat_live[0]), 32'd0);
        clear_bits(3'b010); settle(1);
        check("R9 other bit clear no effect", 32'(stat_sticky[0]), 32'd1);
        clear_bits(3'b001); settle(1);
        check("R9 w1c", 32'(stat_sticky), 32'd0);

        // R8: termination faults with drivers off are hidden
        pin_en_a = 1'b0; term_flt_a = '1; settle(6);
        clear_bits('1); settle(2);
        check("R8 term gated live", 32'(stat_live[SW-1:1]), 32'd0);
        check("R8 term gated sticky", 32'(stat_sticky[SW-1:1]), 32'd0);
        pin_en_a = 1'b1; settle(6);
        check("R8 term visible", 32'(stat_live[SW-1:1]), 32'(3));

        // R6/R7 directed
        sig_ok_a = 1'b0; cfg_los_link = 1'b1; cfg_los_mute = 1'b0; settle(6);
        check("R7 link drops drivers", 32'(drv_en), 32'd0);
        check("R5 offset action", 32'(los_offset), 32'd1);
        cfg_los_link = 1'b0; cfg_los_mute = 1'b1; settle(2);
        check("R6 mute drops drivers", 32'(drv_en), 32'd0);
        cfg_los_mute = 1'b0; settle(2);
        check("R7 no link keeps drivers", 32'(drv_en), 32'(3));

        // Random mix
        for (int it = 0; it < 60; it++) begin
            pin_sd_a     = 1'($urandom);
            pin_en_a     = ($urandom % 4) != 0;
            sig_ok_a     = ($urandom % 3) != 0;
            term_flt_a   = NOUT'($urandom);
            cfg_sd_slow  = 1'($urandom);
            cfg_los_mute = 1'($urandom);
            cfg_los_link = 1'($urandom);
            cfg_mask     = SW'($urandom);
            settle(6);
            check_all();
            clear_bits('1);
            settle(2);
            check("R9 sticky after clear", 32'(stat_sticky), 32'(stat_live));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule